// File: doc/BRIEF.md
# SPI Command Header Generator

This block assembles the command header of a register and bulk-transfer protocol that runs over SPI. On a start strobe it captures an opcode, a 24-bit address, a 32-bit data word, a transfer length, a clockless-access flag and a CRC enable. It then presents the header one byte per accepted beat on a valid/ready byte stream, with the most significant byte of each field first, ready for a serializer.

The header length depends on the opcode. It is 4 to 9 bytes, and its field layout also follows the opcode. When CRC is enabled, the last byte carries a 7-bit CRC over the earlier header bytes, shifted up one place. A start that carries an unknown opcode produces a one-cycle error pulse and no bytes. Starts that arrive while a header is still being sent are ignored.

Top module: `spi_cmd_hdr_gen`

## Requirements
- R1: After reset `busy`, `err`, `tx_valid` and `tx_last` are all 0.
- R2: Accepted opcodes are 0xC1, 0xC2, 0xC3, 0xC4, 0xC5, 0xC6, 0xC7, 0xC8, 0xC9, 0xCA and 0xCF. A start with any other opcode sets `err` high for exactly the one cycle after the capturing edge. It emits no byte and leaves `busy` at 0.
- R3: Opcode 0xCA (single read) sends the opcode, then addr[23:16], addr[15:8] and addr[7:0]. Opcode 0xC9 (single write) sends the same bytes followed by wdata[31:24], [23:16], [15:8] and [7:0].
- R4: Opcodes 0xC4 (internal read) and 0xC3 (internal write) send the opcode, then addr[15:8] with bit 7 forced to 1 when `clockless` is 1, then addr[7:0]. Internal read follows these with one 0x00 byte. Internal write follows them with wdata[31:24] down to wdata[7:0].
- R5: Opcodes 0xC1 and 0xC2 send the opcode, the three address bytes, then xfer_size[15:8] and xfer_size[7:0]. Opcodes 0xC7 and 0xC8 send the opcode, the three address bytes, then xfer_size[23:16], [15:8] and [7:0].
- R6: Opcodes 0xC5 and 0xC6 send the opcode followed by three 0x00 bytes. Opcode 0xCF sends the opcode followed by three 0xFF bytes.
- R7: With `crc_en`=1 one more byte follows the header. It is {crc,1'b0}, where crc is the CRC7 with polynomial x^7+x^3+1, preset to 0x7F, taken over every earlier header byte in order, each byte most significant bit first.
- R8: With `crc_en`=0 the CRC byte is left out, so the frame is one byte shorter and is otherwise identical.
- R9: A byte is consumed only on a cycle with `tx_valid` and `tx_ready` both high. While `tx_ready` is low, `tx_valid` and `tx_data` hold their values. `tx_last` is high only on the final byte.
- R10: `busy` rises on the edge that captures a valid start and falls on the edge that consumes the final byte. A start seen while `busy` is 1 has no effect on the frame being sent and does not queue another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture strobe for the command inputs |
| opcode | input | 8 | Command code |
| addr | input | 24 | Target address |
| wdata | input | 32 | Write data word |
| xfer_size | input | 24 | Transfer length field |
| clockless | input | 1 | Sets bit 7 of the internal address high byte |
| crc_en | input | 1 | Append the CRC byte |
| busy | output | 1 | A header is being emitted |
| err | output | 1 | One-cycle pulse on an unknown opcode |
| tx_valid | output | 1 | Byte stream valid |
| tx_data | output | 8 | Header byte |
| tx_last | output | 1 | Final byte of the header |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The assertions watch the stream handshake on every cycle. They check that a stalled byte holds, that an accepted last byte ends `busy`, that an error pulse never coincides with traffic and always follows a start, that `busy` only rises after a start, and that a trailing CRC byte has bit 0 clear. The byte contents of each opcode's layout and the CRC values themselves can only be shown by the bench scenarios. These compare full frames against an independently computed header. The bench scenarios also cover the error pulse width and starts that arrive while the block is busy.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 9;
  localparam int LEN_W     = $clog2(MAX_BYTES + 1);
  localparam int IDX_W     = $clog2(MAX_BYTES);
  localparam int FRAME_W   = MAX_BYTES * BYTE_W;
  localparam int ADDR_W    = 24;
  localparam int DATA_W    = 32;
  localparam int SIZE_W    = 24;
  localparam int CRC_W     = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;
  localparam logic [CRC_W-1:0] CRC_INIT = 7'h7F;

  typedef enum logic [BYTE_W-1:0] {
    OP_BULK_WR   = 8'hC1,
    OP_BULK_RD   = 8'hC2,
    OP_LOC_WR    = 8'hC3,
    OP_LOC_RD    = 8'hC4,
    OP_STOP      = 8'hC5,
    OP_AGAIN     = 8'hC6,
    OP_BULKX_WR  = 8'hC7,
    OP_BULKX_RD  = 8'hC8,
    OP_WORD_WR   = 8'hC9,
    OP_WORD_RD   = 8'hCA,
    OP_RESTART   = 8'hCF
  } op_e;

  // One byte through the CRC7 register, most significant bit first.
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c,
                                                 input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/sfb_layout.sv
module sfb_layout
  import sfb_pkg::*;
(
  input  logic [BYTE_W-1:0]  opcode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [SIZE_W-1:0]  xfer_size,
  input  logic               clockless,
  output logic [FRAME_W-1:0] body,
  output logic [LEN_W-1:0]   body_len,
  output logic               known
);
  logic [BYTE_W-1:0] b [MAX_BYTES];
  logic [BYTE_W-1:0] loc_hi;

  assign loc_hi = {addr[15] | clockless, addr[14:8]};

  always_comb begin
    for (int i = 0; i < MAX_BYTES; i++) b[i] = '0;
    b[0]     = opcode;
    body_len = LEN_W'(4);
    known    = 1'b1;
    case (opcode)
      OP_WORD_RD: begin
        b[1] = addr[23:16]; b[2] = addr[15:8]; b[3] = addr[7:0];
      end
      OP_WORD_WR: begin
        b[1] = addr[23:16]; b[2] = addr[15:8]; b[3] = addr[7:0];
        b[4] = wdata[31:24]; b[5] = wdata[23:16];
        b[6] = wdata[15:8];  b[7] = wdata[7:0];
        body_len = LEN_W'(8);
      end
      OP_LOC_RD: begin
        b[1] = loc_hi; b[2] = addr[7:0]; b[3] = 8'h00;
      end
      OP_LOC_WR: begin
        b[1] = loc_hi; b[2] = addr[7:0];
        b[3] = wdata[31:24]; b[4] = wdata[23:16];
        b[5] = wdata[15:8];  b[6] = wdata[7:0];
        body_len = LEN_W'(7);
      end
      OP_BULK_WR, OP_BULK_RD: begin
        b[1] = addr[23:16]; b[2] = addr[15:8]; b[3] = addr[7:0];
        b[4] = xfer_size[15:8]; b[5] = xfer_size[7:0];
        body_len = LEN_W'(6);
      end
      OP_BULKX_WR, OP_BULKX_RD: begin
        b[1] = addr[23:16]; b[2] = addr[15:8]; b[3] = addr[7:0];
        b[4] = xfer_size[23:16]; b[5] = xfer_size[15:8]; b[6] = xfer_size[7:0];
        body_len = LEN_W'(7);
      end
      OP_STOP, OP_AGAIN: begin
        b[1] = 8'h00; b[2] = 8'h00; b[3] = 8'h00;
      end
      OP_RESTART: begin
        b[1] = 8'hFF; b[2] = 8'hFF; b[3] = 8'hFF;
      end
      default: known = 1'b0;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < MAX_BYTES; g++) begin : g_pack
      assign body[g*BYTE_W +: BYTE_W] = b[g];
    end
  endgenerate
endmodule

// File: rtl/sfb_crc7.sv
module sfb_crc7
  import sfb_pkg::*;
(
  input  logic [FRAME_W-1:0] bytes_in,
  input  logic [LEN_W-1:0]   count,
  output logic [CRC_W-1:0]   crc
);
  logic [CRC_W-1:0] stage [MAX_BYTES+1];
  assign stage[0] = CRC_INIT;

  genvar g;
  generate
    for (g = 0; g < MAX_BYTES; g++) begin : g_chain
      assign stage[g+1] = (LEN_W'(g) < count)
                        ? crc7_step(stage[g], bytes_in[g*BYTE_W +: BYTE_W])
                        : stage[g];
    end
  endgenerate

  assign crc = stage[MAX_BYTES];
endmodule

// File: rtl/sfb_tx.sv
module sfb_tx
  import sfb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               known,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   len,
  input  logic               crc_on,
  output logic               busy,
  output logic               err,
  output logic               tx_valid,
  output logic [BYTE_W-1:0]  tx_data,
  output logic               tx_last,
  input  logic               tx_ready
);
  logic [FRAME_W-1:0] frame_q;
  logic [LEN_W-1:0]   len_q;
  logic [IDX_W-1:0]   idx_q;
  logic               crc_q;
  logic               beat, launch, reject;

  assign launch   = start && !busy && known;
  assign reject   = start && !busy && !known;
  assign tx_valid = busy;
  assign tx_data  = frame_q[idx_q*BYTE_W +: BYTE_W];
  assign tx_last  = busy && (LEN_W'(idx_q) == len_q - LEN_W'(1));
  assign beat     = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      err     <= 1'b0;
      frame_q <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      crc_q   <= 1'b0;
    end else begin
      err <= reject;
      if (launch) begin
        busy    <= 1'b1;
        frame_q <= frame;
        len_q   <= len;
        crc_q   <= crc_on;
        idx_q   <= '0;
      end else if (beat) begin
        if (tx_last) busy  <= 1'b0;
        else         idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R10
  last_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && tx_last) |=> !busy);
  // R10
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!tx_valid && $past(start)));
  // R7
  crc_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last && crc_q) |-> !tx_data[0]);
  // R9
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (LEN_W'(idx_q) < len_q));
endmodule

// File: rtl/spi_cmd_hdr_gen.sv
module spi_cmd_hdr_gen
  import sfb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [23:0] addr,
  input  logic [31:0] wdata,
  input  logic [23:0] xfer_size,
  input  logic        clockless,
  input  logic        crc_en,
  output logic        busy,
  output logic        err,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  logic [FRAME_W-1:0] body, frame;
  logic [LEN_W-1:0]   body_len, frame_len;
  logic               known;
  logic [CRC_W-1:0]   crc;

  sfb_layout u_layout (
    .opcode(opcode), .addr(addr), .wdata(wdata), .xfer_size(xfer_size),
    .clockless(clockless), .body(body), .body_len(body_len), .known(known)
  );

  sfb_crc7 u_crc (.bytes_in(body), .count(body_len), .crc(crc));

  // Drop the CRC byte into the slot right after the body.
  always_comb begin
    frame     = body;
    frame_len = body_len;
    if (crc_en) begin
      frame[body_len*BYTE_W +: BYTE_W] = {crc, 1'b0};
      frame_len = body_len + LEN_W'(1);
    end
  end

  sfb_tx u_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .known(known), .frame(frame),
    .len(frame_len), .crc_on(crc_en), .busy(busy), .err(err),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );
endmodule

// File: tb/spi_cmd_hdr_gen_test.sv
`timescale 1ns/1ps
module spi_cmd_hdr_gen_test;
  logic clk = 0, rst_n = 0, start = 0, clockless = 0, crc_en = 0, tx_ready = 0;
  logic [7:0] opcode = 0;
  logic [23:0] addr = 0, xfer_size = 0;
  logic [31:0] wdata = 0;
  logic busy, err, tx_valid, tx_last;
  logic [7:0] tx_data;
  int checks = 0, failures = 0;
  logic [7:0] exp_b [10];
  int exp_n;

  always #2 clk = ~clk;

  spi_cmd_hdr_gen uut (.*);

  function automatic logic [6:0] ref_crc(input int n);
    logic [6:0] r = 7'h7F;
    for (int i = 0; i < n; i++)
      for (int k = 7; k >= 0; k--) begin
        logic top = r[6];
        r = {r[5:0], 1'b0} ^ ((top ^ exp_b[i][k]) ? 7'b0001001 : 7'b0);
      end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic build(input logic [7:0] op, input logic [23:0] a,
                       input logic [31:0] d, input logic [23:0] s,
                       input bit cl, input bit crc);
    exp_b[0] = op;
    case (op)
      8'hCA, 8'hC9: begin
        exp_b[1] = a[23:16]; exp_b[2] = a[15:8]; exp_b[3] = a[7:0]; exp_n = 4;
        if (op == 8'hC9) begin
          for (int i = 0; i < 4; i++) exp_b[4+i] = d[31-8*i -: 8];
          exp_n = 8;
        end
      end
      8'hC4, 8'hC3: begin
        exp_b[1] = a[15:8] | (cl ? 8'h80 : 8'h00); exp_b[2] = a[7:0];
        if (op == 8'hC4) begin exp_b[3] = 0; exp_n = 4; end
        else begin
          for (int i = 0; i < 4; i++) exp_b[3+i] = d[31-8*i -: 8];
          exp_n = 7;
        end
      end
      8'hC1, 8'hC2: begin
        exp_b[1] = a[23:16]; exp_b[2] = a[15:8]; exp_b[3] = a[7:0];
        exp_b[4] = s[15:8]; exp_b[5] = s[7:0]; exp_n = 6;
      end
      8'hC7, 8'hC8: begin
        exp_b[1] = a[23:16]; exp_b[2] = a[15:8]; exp_b[3] = a[7:0];
        exp_b[4] = s[23:16]; exp_b[5] = s[15:8]; exp_b[6] = s[7:0]; exp_n = 7;
      end
      default: begin
        for (int i = 1; i < 4; i++) exp_b[i] = (op == 8'hCF) ? 8'hFF : 8'h00;
        exp_n = 4;
      end
    endcase
    if (crc) begin exp_b[exp_n] = {ref_crc(exp_n), 1'b0}; exp_n++; end
  endtask

  // Send one header, collect it and compare against the bench's own layout.
  task automatic run_frame(input string req, input logic [7:0] op,
                           input logic [23:0] a, input logic [31:0] d,
                           input logic [23:0] s, input bit cl, input bit crc,
                           input bit stall, input bit poke);
    logic [7:0] got [10];
    int n = 0, last_at = -1, bad = -1;
    bit done = 0, held = 0, hold_ok = 1;
    logic [7:0] held_v = 0;
    build(op, a, d, s, cl, crc);
    @(negedge clk);
    opcode = op; addr = a; wdata = d; xfer_size = s; clockless = cl; crc_en = crc;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 40 && !done; k++) begin
      if (poke && k == 1) begin start = 1; opcode = 8'hCF; addr = 24'h0; end
      if (poke && k == 2) start = 0;
      if (held) begin
        if (!tx_valid || tx_data != held_v) hold_ok = 0;
        held = 0;
      end
      tx_ready = stall ? (k % 2 == 1) : 1'b1;
      if (tx_valid && tx_ready) begin
        if (n < 10) got[n] = tx_data;
        if (tx_last) begin last_at = n; done = 1; end
        n++;
      end else if (tx_valid) begin
        held = 1; held_v = tx_data;
      end
      @(negedge clk);
    end
    tx_ready = 0; start = 0;
    check(n == exp_n, req, "frame length", 64'(n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < n; i++)
      if (bad < 0 && got[i] !== exp_b[i]) bad = i;
    check(bad < 0, req, "frame bytes",
          bad < 0 ? 64'd0 : 64'(got[bad]), bad < 0 ? 64'd0 : 64'(exp_b[bad]));
    check(last_at == exp_n - 1, "R9", "last flag position", 64'(last_at), 64'(exp_n - 1));
    if (stall) check(hold_ok, "R9", "byte held while stalled", 64'(hold_ok), 64'd1);
    check(!busy && !tx_valid, "R10", "idle after final byte", 64'(busy), 64'd0);
    if (poke) begin
      bit quiet = 1;
      for (int k = 0; k < 4; k++) begin
        if (tx_valid || err) quiet = 0;
        @(negedge clk);
      end
      check(quiet, "R10", "no frame from start while busy", 64'(quiet), 64'd1);
    end
  endtask

  task automatic bad_op(input logic [7:0] op);
    @(negedge clk);
    opcode = op; start = 1;
    @(negedge clk);
    start = 0;
    check(err && !tx_valid && !busy, "R2", "error pulse, no traffic",
          {err, tx_valid, busy}, 3'b100);
    @(negedge clk);
    check(!err && !tx_valid, "R2", "error lasts one cycle", {err, tx_valid}, 2'b00);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !err && !tx_valid && !tx_last, "R1", "reset state",
          {busy, err, tx_valid, tx_last}, 4'b0);
    rst_n = 1;
    @(negedge clk);
    run_frame("R3", 8'hC9, 24'h123456, 32'hDEADBEEF, 0, 0, 1, 1, 0);
    run_frame("R3", 8'hCA, 24'hA5C3E1, 0, 0, 0, 1, 0, 0);
    run_frame("R8", 8'hCA, 24'hA5C3E1, 0, 0, 0, 0, 0, 0);
    run_frame("R4", 8'hC4, 24'h00102A, 0, 0, 1, 1, 0, 0);
    run_frame("R4", 8'hC3, 24'h00E824, 32'h01020304, 0, 0, 1, 1, 0);
    run_frame("R4", 8'hC3, 24'h000010, 32'hCAFEF00D, 0, 1, 0, 0, 0);
    run_frame("R5", 8'hC2, 24'h7F0001, 0, 24'h00ABCD, 0, 1, 0, 0);
    run_frame("R5", 8'hC1, 24'h010203, 0, 24'hFF1234, 0, 0, 1, 0);
    run_frame("R5", 8'hC7, 24'h0A0B0C, 0, 24'h123456, 0, 1, 1, 0);
    run_frame("R5", 8'hC8, 24'hFFFFFF, 0, 24'h800001, 0, 1, 0, 0);
    run_frame("R6", 8'hC5, 24'hFFFFFF, 32'hFFFFFFFF, 24'hFFFFFF, 1, 1, 0, 0);
    run_frame("R6", 8'hC6, 24'h123456, 0, 0, 0, 1, 0, 0);
    run_frame("R6", 8'hCF, 24'h000000, 0, 0, 0, 1, 1, 0);
    run_frame("R7", 8'hC9, 24'h000000, 32'h00000000, 0, 0, 1, 0, 0);
    run_frame("R10", 8'hCA, 24'h445566, 0, 0, 0, 1, 1, 1);
    bad_op(8'hC0);
    bad_op(8'hCB);
    bad_op(8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule